// File: doc/BRIEF.md
# Branch Target Fetch Buffer

This block sits in an instruction prefetch unit. It keeps a small, fully associative set of recently taken direct branches. For each one it stores the instruction fetch groups found at the branch target. The branch predictor presents every branch it has marked as taken. When that branch is a direct one, either plain or with link, the buffer is searched in the same cycle using the branch address and the target address. On a hit, the stored fetch groups go to the fetch pipeline in place of an instruction-cache access. This removes the empty fetch slot after the taken branch. The block also supplies the address at which sequential fetching should resume.

On a miss, the block watches the instruction-cache read data. It captures the first group returned for the target address and then the group that follows it. When both have arrived, it writes a new entry. If the next eligible branch arrives after the first group but before the second, the entry is written with one group only.

Each entry is tagged with the full branch address and the full target address. Only an exact match of both counts as a hit, so the stored contents can never alter program behaviour. Nothing has to be cleared on a context switch. A single-cycle invalidate input clears everything, for cache maintenance or code changes. A mispredict input discards any fill that is still collecting data.

Top module: `target_fetch_buf`

## Requirements
- R1: After synchronous reset every entry is invalid, so no lookup hits until a fill has completed.
- R2: Only a cycle with `br_valid` high and `br_kind` equal to 2'b01 (plain direct) or 2'b10 (direct with link) is looked up or starts a fill. Kinds 2'b00 and 2'b11 never raise `hit` and never allocate an entry.
- R3: A lookup is combinational: `hit`, `hit_group0`, `hit_group1` and `hit_two` are valid in the same cycle as the branch request.
- R4: A hit needs both the stored branch address and the stored target address to equal `br_pc` and `br_target` exactly.
- R5: After a miss, the first `ic_valid` cycle whose `ic_addr` equals the target supplies group 0. The first later `ic_valid` cycle whose `ic_addr` equals the target plus 8 bytes (one 64-bit group) supplies group 1, and the entry is written with both groups valid.
- R6: If an eligible branch arrives while group 1 is still awaited, the pending entry is written with only group 0 valid. A hit on it shows `hit_two` low and `hit_group1` zero.
- R7: On a hit, `resume_addr` is the target plus 16 when two groups are valid and the target plus 8 when one is. Without a hit, `resume_addr` equals `br_target`.
- R8: A written entry replaces an entry with the same tags if one exists. Otherwise it goes to the lowest-numbered invalid entry. When all four entries are valid, it goes to the entry named by a round-robin pointer that starts at 0 after reset and advances only on such replacements.
- R9: `inval_all` clears every entry in one cycle and discards a fill in progress, so data arriving afterwards for that fill is never written.
- R10: `mispredict` cancels any fill in progress, leaving no entry for that branch. It also prevents a fill from starting or completing in the same cycle.
- R11: An eligible branch arriving before the first group of a pending fill has been captured abandons that fill without writing an entry.
- R12: No two valid entries ever carry the same tag pair. A refill of an already stored branch replaces the older entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Predictor presents a predicted-taken branch |
| br_kind | input | 2 | Branch kind: 01 plain direct, 10 direct with link, others bypass |
| br_pc | input | 32 | Address of the branch instruction |
| br_target | input | 32 | Predicted target address |
| ic_valid | input | 1 | Instruction-cache read data valid |
| ic_addr | input | 32 | Address of the returned fetch group |
| ic_data | input | 64 | Returned fetch group |
| mispredict | input | 1 | Branch resolved as mispredicted; cancel pending fill |
| inval_all | input | 1 | Clear all entries and any pending fill |
| hit | output | 1 | Lookup hit this cycle |
| hit_group0 | output | 64 | First stored fetch group at the target |
| hit_group1 | output | 64 | Second stored fetch group, zero if absent |
| hit_two | output | 1 | Second stored group is valid |
| resume_addr | output | 32 | Address where sequential fetch resumes |

## Verification
Several properties are checked on every cycle. A hit only ever follows a direct-kind request, at most one entry matches a lookup, the store is empty the cycle after an invalidate, and no entry is written while a cancel or invalidate is active or while the first group is still awaited. The bench scenarios cover what needs a history of events. These are the contents and group count returned after a fill, the one-group commit cut short by a following branch, exact-tag misses, round-robin eviction once the buffer is full, and the absence of entries after cancelled or abandoned fills. A random phase with small address pools compares every output against a bench-side model of the rules above.

// File: rtl/tfb_pkg.sv
package tfb_pkg;
    localparam int ADDR_W      = 32;
    localparam int GROUP_W     = 64;
    localparam int GROUP_BYTES = GROUP_W / 8;
    localparam int NUM_ENT_DEF = 4;

    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [GROUP_W-1:0] grp_t;

    typedef enum logic [1:0] {
        BR_OTHER    = 2'b00,
        BR_PLAIN    = 2'b01,
        BR_LINK     = 2'b10,
        BR_INDIRECT = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_WAIT0 = 2'd1,
        FS_WAIT1 = 2'd2
    } fill_st_e;

    typedef struct packed {
        addr_t      src;
        addr_t      dst;
        grp_t       g0;
        grp_t       g1;
        logic [1:0] gv;
    } line_t;

    function automatic addr_t step_groups(addr_t a, int unsigned n);
        return a + addr_t'(n * GROUP_BYTES);
    endfunction

    function automatic logic is_direct(logic [1:0] k);
        return (k == BR_PLAIN) || (k == BR_LINK);
    endfunction
endpackage

// File: rtl/tfb_store.sv
module tfb_store
    import tfb_pkg::*;
#(
    parameter int NUM_ENT = NUM_ENT_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       inval,
    input  addr_t      lk_src,
    input  addr_t      lk_dst,
    output logic       lk_hit,
    output grp_t       lk_g0,
    output grp_t       lk_g1,
    output logic [1:0] lk_gv,
    input  logic       wr_en,
    input  line_t      wr_line
);
    localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

    line_t              ent [NUM_ENT];
    logic [NUM_ENT-1:0] vld;
    logic [NUM_ENT-1:0] hit_vec;
    logic [NUM_ENT-1:0] same_vec;
    logic [IDX_W-1:0]   rr;
    logic [IDX_W-1:0]   vic;
    logic               use_rr;

    for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
        assign hit_vec[i]  = vld[i] && ent[i].src == lk_src  && ent[i].dst == lk_dst;
        assign same_vec[i] = vld[i] && ent[i].src == wr_line.src && ent[i].dst == wr_line.dst;
    end

    always_comb begin
        lk_g0 = '0;
        lk_g1 = '0;
        lk_gv = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (hit_vec[i]) begin
                lk_g0 = ent[i].g0;
                lk_g1 = ent[i].g1;
                lk_gv = ent[i].gv;
            end
        end
    end
    assign lk_hit = |hit_vec;

    always_comb begin
        logic found;
        found  = 1'b0;
        vic    = rr;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!found && same_vec[i]) begin
                vic   = IDX_W'(i);
                found = 1'b1;
            end
        end
        for (int i = 0; i < NUM_ENT; i++) begin
            if (!found && !vld[i]) begin
                vic   = IDX_W'(i);
                found = 1'b1;
            end
        end
        use_rr = !found;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            rr  <= '0;
        end else if (inval) begin
            vld <= '0;
        end else if (wr_en) begin
            vld[vic] <= 1'b1;
            if (use_rr)
                rr <= (rr == IDX_W'(NUM_ENT - 1)) ? '0 : rr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && !inval && !rst)
            ent[vic] <= wr_line;
    end

    // R12: never more than one matching entry
    p_single_match_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R9: an invalidate leaves the store empty on the next cycle
    p_inval_empties_r9: assert property (@(posedge clk) disable iff (rst)
        inval |=> (vld == '0));
endmodule

// File: rtl/tfb_fill.sv
module tfb_fill
    import tfb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cancel,
    input  logic  inval,
    input  logic  br_elig,
    input  logic  br_hit,
    input  addr_t br_src,
    input  addr_t br_dst,
    input  logic  ic_valid,
    input  addr_t ic_addr,
    input  grp_t  ic_data,
    output logic  wr_en,
    output line_t wr_line
);
    fill_st_e st, st_nx;
    addr_t    f_src, f_dst;
    grp_t     f_g0;
    logic     load, cap;

    always_comb begin
        st_nx   = st;
        load    = 1'b0;
        cap     = 1'b0;
        wr_en   = 1'b0;
        wr_line = '{src: f_src, dst: f_dst, g0: f_g0, g1: ic_data, gv: 2'b11};
        if (inval || cancel) begin
            st_nx = FS_IDLE;
        end else if (br_elig) begin
            if (st == FS_WAIT1) begin
                wr_en      = 1'b1;
                wr_line.g1 = '0;
                wr_line.gv = 2'b01;
            end
            load  = !br_hit;
            st_nx = br_hit ? FS_IDLE : FS_WAIT0;
        end else begin
            unique case (st)
                FS_WAIT0: if (ic_valid && ic_addr == f_dst) begin
                    cap   = 1'b1;
                    st_nx = FS_WAIT1;
                end
                FS_WAIT1: if (ic_valid && ic_addr == step_groups(f_dst, 1)) begin
                    wr_en = 1'b1;
                    st_nx = FS_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= FS_IDLE;
            f_src <= '0;
            f_dst <= '0;
            f_g0  <= '0;
        end else begin
            st <= st_nx;
            if (load) begin
                f_src <= br_src;
                f_dst <= br_dst;
            end
            if (cap)
                f_g0 <= ic_data;
        end
    end

    // R10: a cancel leaves no fill pending
    p_cancel_idles_r10: assert property (@(posedge clk) disable iff (rst)
        cancel |=> (st == FS_IDLE));

    // R9 / R10: nothing is written during invalidate or cancel
    p_no_write_on_kill_r10: assert property (@(posedge clk) disable iff (rst)
        (inval || cancel) |-> !wr_en);

    // R11: no entry is written while the first group is awaited
    p_wait0_silent_r11: assert property (@(posedge clk) disable iff (rst)
        (st == FS_WAIT0) |-> !wr_en);
endmodule

// File: rtl/target_fetch_buf.sv
module target_fetch_buf
    import tfb_pkg::*;
#(
    parameter int NUM_ENT = NUM_ENT_DEF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               br_valid,
    input  logic [1:0]         br_kind,
    input  logic [ADDR_W-1:0]  br_pc,
    input  logic [ADDR_W-1:0]  br_target,
    input  logic               ic_valid,
    input  logic [ADDR_W-1:0]  ic_addr,
    input  logic [GROUP_W-1:0] ic_data,
    input  logic               mispredict,
    input  logic               inval_all,
    output logic               hit,
    output logic [GROUP_W-1:0] hit_group0,
    output logic [GROUP_W-1:0] hit_group1,
    output logic               hit_two,
    output logic [ADDR_W-1:0]  resume_addr
);
    logic       elig;
    logic       st_hit;
    grp_t       st_g0, st_g1;
    logic [1:0] st_gv;
    logic       wr_en;
    line_t      wr_line;

    assign elig = br_valid && is_direct(br_kind);

    tfb_store #(.NUM_ENT(NUM_ENT)) u_store (
        .clk     (clk),
        .rst     (rst),
        .inval   (inval_all),
        .lk_src  (br_pc),
        .lk_dst  (br_target),
        .lk_hit  (st_hit),
        .lk_g0   (st_g0),
        .lk_g1   (st_g1),
        .lk_gv   (st_gv),
        .wr_en   (wr_en),
        .wr_line (wr_line)
    );

    tfb_fill u_fill (
        .clk      (clk),
        .rst      (rst),
        .cancel   (mispredict),
        .inval    (inval_all),
        .br_elig  (elig),
        .br_hit   (st_hit),
        .br_src   (br_pc),
        .br_dst   (br_target),
        .ic_valid (ic_valid),
        .ic_addr  (ic_addr),
        .ic_data  (ic_data),
        .wr_en    (wr_en),
        .wr_line  (wr_line)
    );

    assign hit         = elig && st_hit;
    assign hit_two     = hit && st_gv[1];
    assign hit_group0  = hit ? st_g0 : '0;
    assign hit_group1  = hit_two ? st_g1 : '0;
    assign resume_addr = !hit ? br_target : step_groups(br_target, hit_two ? 2 : 1);

    // R2: a hit is only ever reported for a direct-kind request
    p_hit_direct_only_r2: assert property (@(posedge clk) disable iff (rst)
        hit |-> (br_valid && (br_kind == 2'b01 || br_kind == 2'b10)));
endmodule

// File: tb/sim_target_fetch_buf.sv
module sim_target_fetch_buf;
    import tfb_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid, ic_valid, mispredict, inval_all;
    logic [1:0]  br_kind;
    addr_t       br_pc, br_target, ic_addr;
    grp_t        ic_data;
    logic        hit, hit_two;
    grp_t        hit_group0, hit_group1;
    addr_t       resume_addr;

    int total = 0;
    int bad   = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    target_fetch_buf u0 (
        .clk(clk), .rst(rst), .br_valid(br_valid), .br_kind(br_kind),
        .br_pc(br_pc), .br_target(br_target), .ic_valid(ic_valid),
        .ic_addr(ic_addr), .ic_data(ic_data), .mispredict(mispredict),
        .inval_all(inval_all), .hit(hit), .hit_group0(hit_group0),
        .hit_group1(hit_group1), .hit_two(hit_two), .resume_addr(resume_addr)
    );

    // bench model of the rules in the requirements
    logic  m_v   [4];
    addr_t m_pc  [4];
    addr_t m_tg  [4];
    grp_t  m_d0  [4];
    grp_t  m_d1  [4];
    logic  m_two [4];
    int    m_rr;
    int    f_st;
    addr_t f_pc, f_tg;
    grp_t  f_d0;

    function automatic int m_find(addr_t pc, addr_t tg);
        for (int i = 0; i < 4; i++)
            if (m_v[i] && m_pc[i] == pc && m_tg[i] == tg) return i;
        return -1;
    endfunction

    function automatic void m_reset();
        for (int i = 0; i < 4; i++) m_v[i] = 1'b0;
        m_rr = 0;
        f_st = 0;
    endfunction

    function automatic void m_commit(addr_t pc, addr_t tg, grp_t a, grp_t b, logic two);
        int k;
        k = m_find(pc, tg);
        if (k < 0)
            for (int i = 0; i < 4; i++) if (k < 0 && !m_v[i]) k = i;
        if (k < 0) begin
            k = m_rr;
            m_rr = (m_rr + 1) % 4;
        end
        m_v[k] = 1'b1; m_pc[k] = pc; m_tg[k] = tg;
        m_d0[k] = a; m_d1[k] = two ? b : '0; m_two[k] = two;
    endfunction

    function automatic void m_step();
        logic el;
        int   k;
        el = br_valid && (br_kind == 2'b01 || br_kind == 2'b10);
        k  = m_find(br_pc, br_target);
        if (inval_all) begin
            for (int i = 0; i < 4; i++) m_v[i] = 1'b0;
            f_st = 0;
        end else if (mispredict) begin
            f_st = 0;
        end else if (el) begin
            if (f_st == 2) m_commit(f_pc, f_tg, f_d0, '0, 1'b0);
            if (k < 0) begin
                f_st = 1; f_pc = br_pc; f_tg = br_target;
            end else f_st = 0;
        end else if (f_st == 1 && ic_valid && ic_addr == f_tg) begin
            f_d0 = ic_data; f_st = 2;
        end else if (f_st == 2 && ic_valid && ic_addr == f_tg + 8) begin
            m_commit(f_pc, f_tg, f_d0, ic_data, 1'b1);
            f_st = 0;
        end
    endfunction

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", cur_tag, what, act, exp);
        end
    endtask

    task automatic compare();
        logic el;
        int   k;
        el = br_valid && (br_kind == 2'b01 || br_kind == 2'b10);
        k  = el ? m_find(br_pc, br_target) : -1;
        chk("hit", 64'(hit), 64'(k >= 0));
        if (br_valid) begin
            if (k >= 0) begin
                chk("group0", hit_group0, m_d0[k]);
                chk("group1", hit_group1, m_d1[k]);
                chk("two", 64'(hit_two), 64'(m_two[k]));
                chk("resume", 64'(resume_addr), 64'(br_target + (m_two[k] ? 16 : 8)));
            end else begin
                chk("resume", 64'(resume_addr), 64'(br_target));
            end
        end
    endtask

    task automatic cyc(logic bv, logic [1:0] kd, addr_t pc, addr_t tg,
                       logic icv, addr_t ia, grp_t id, logic mp, logic inv);
        @(negedge clk);
        br_valid = bv; br_kind = kd; br_pc = pc; br_target = tg;
        ic_valid = icv; ic_addr = ia; ic_data = id;
        mispredict = mp; inval_all = inv;
        #1;
        compare();
        m_step();
    endtask

    task automatic idle();
        cyc(0, 2'b00, '0, '0, 0, '0, '0, 0, 0);
    endtask

    task automatic br(addr_t pc, addr_t tg);
        cyc(1, 2'b01, pc, tg, 0, '0, '0, 0, 0);
    endtask

    task automatic ic(addr_t a, grp_t d);
        cyc(0, 2'b00, '0, '0, 1, a, d, 0, 0);
    endtask

    task automatic fill_two(addr_t pc, addr_t tg, grp_t a, grp_t b);
        br(pc, tg);
        ic(tg, a);
        ic(tg + 8, b);
        idle();
    endtask

    // fixed-expectation check of a single lookup, independent of the model
    task automatic expect_lookup(string tg_name, addr_t pc, addr_t tg, logic eh,
                                 logic etwo, grp_t e0);
        cur_tag = tg_name;
        @(negedge clk);
        br_valid = 1; br_kind = 2'b10; br_pc = pc; br_target = tg;
        ic_valid = 0; mispredict = 0; inval_all = 0;
        #1;
        chk("direct hit", 64'(hit), 64'(eh));
        if (eh) begin
            chk("direct two", 64'(hit_two), 64'(etwo));
            chk("direct group0", hit_group0, e0);
            chk("direct resume", 64'(resume_addr), 64'(tg + (etwo ? 16 : 8)));
        end
        m_step();
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        br_valid = 0; br_kind = 0; br_pc = 0; br_target = 0;
        ic_valid = 0; ic_addr = 0; ic_data = 0; mispredict = 0; inval_all = 0;
        rst = 1;
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        cur_tag = "R1";
        br(32'h1000, 32'h2000);
        expect_lookup("R1", 32'h1000, 32'h2000, 0, 0, '0);
        idle();

        // R5 / R3 / R7: two-group fill then hit
        cur_tag = "R5";
        ic(32'h2000, 64'h0);
        fill_two(32'h1000, 32'h2000, 64'hAAAA_0000_0000_0001, 64'hAAAA_0000_0000_0002);
        expect_lookup("R3", 32'h1000, 32'h2000, 1, 1, 64'hAAAA_0000_0000_0001);
        cur_tag = "R7";
        br(32'h1000, 32'h2000);
        idle();

        // R6 / R11: one-group commit, abandoned follower
        cur_tag = "R6";
        br(32'h1100, 32'h3000);
        ic(32'h3000, 64'hBBBB_0000_0000_0001);
        br(32'h1200, 32'h4000);
        br(32'h1100, 32'h3000);
        idle();
        expect_lookup("R6", 32'h1100, 32'h3000, 1, 0, 64'hBBBB_0000_0000_0001);
        idle();
        ic(32'h4000, 64'h1);
        ic(32'h4008, 64'h2);
        expect_lookup("R11", 32'h1200, 32'h4000, 0, 0, '0);
        idle();

        // R4: exact tag match
        expect_lookup("R4", 32'h1000, 32'h2008, 0, 0, '0);
        idle();
        expect_lookup("R4", 32'h1004, 32'h2000, 0, 0, '0);
        idle();

        // R2: other kinds bypass
        cur_tag = "R2";
        cyc(1, 2'b00, 32'h1000, 32'h2000, 0, '0, '0, 0, 0);
        cyc(1, 2'b11, 32'h1000, 32'h2000, 0, '0, '0, 0, 0);
        cyc(1, 2'b11, 32'h1300, 32'h5000, 0, '0, '0, 0, 0);
        ic(32'h5000, 64'h5); ic(32'h5008, 64'h6);
        expect_lookup("R2", 32'h1300, 32'h5000, 0, 0, '0);
        idle();

        // R10: mispredict cancels fill
        cur_tag = "R10";
        br(32'h1400, 32'h6000);
        ic(32'h6000, 64'h7);
        cyc(0, 2'b00, '0, '0, 0, '0, '0, 1, 0);
        ic(32'h6008, 64'h8);
        expect_lookup("R10", 32'h1400, 32'h6000, 0, 0, '0);
        idle();

        // R9: invalidate clears and discards pending fill
        cur_tag = "R9";
        br(32'h1500, 32'h7000);
        ic(32'h7000, 64'h9);
        cyc(0, 2'b00, '0, '0, 0, '0, '0, 0, 1);
        ic(32'h7008, 64'hA);
        expect_lookup("R9", 32'h1500, 32'h7000, 0, 0, '0);
        idle();
        expect_lookup("R9", 32'h1000, 32'h2000, 0, 0, '0);
        idle();

        // R8: fill invalids first, then round robin from entry 0
        cur_tag = "R8";
        for (int i = 0; i < 6; i++)
            fill_two(32'h8000 + 32'(i * 4), 32'h9000 + 32'(i * 64), 64'(i + 100), 64'(i + 200));
        expect_lookup("R8", 32'h8000, 32'h9000, 0, 0, '0);
        idle();
        expect_lookup("R8", 32'h8004, 32'h9040, 0, 0, '0);
        idle();
        expect_lookup("R8", 32'h8008, 32'h9080, 1, 1, 64'd102);
        idle();
        expect_lookup("R8", 32'h8014, 32'h9140, 1, 1, 64'd105);
        idle();

        // R12: refill of a stored branch replaces, not duplicates
        cur_tag = "R12";
        cyc(0, 2'b00, '0, '0, 0, '0, '0, 0, 1);
        br(32'hA000, 32'hB000);
        ic(32'hB000, 64'h11);
        br(32'hA000, 32'hB000);
        ic(32'hB000, 64'h21);
        ic(32'hB008, 64'h22);
        idle();
        expect_lookup("R12", 32'hA000, 32'hB000, 1, 1, 64'h21);
        idle();

        // random phase against the model (R3 and all rules)
        cur_tag = "R3";
        for (int n = 0; n < 4000; n++) begin
            int unsigned r, p, t;
            r = $urandom;
            p = $urandom_range(0, 5);
            t = p % 3;
            cyc(r[3:0] < 5, r[5:4], 32'hC000 + 32'(p * 4), 32'hD000 + 32'(t * 32),
                r[8:6] < 5, 32'hD000 + 32'($urandom_range(0, 2) * 32) + (r[9] ? 32'd8 : 32'd0),
                {32'(n), 32'($urandom)}, r[15:10] == 0, r[23:16] == 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule